// File: doc/BRIEF.md
# Programmable Clock-Enable Prescaler

This block turns a fast oscillator clock into the slower rate at which a processor core and its peripherals advance. An 8-bit divide setting selects an even ratio between 2 and 512: the ratio is 512 minus twice the setting. A bypass bit lets every oscillator cycle through undivided. The block produces two forms of the divided rate. `ce_o` is a single-cycle enable pulse for logic clocked by the oscillator. `clk_div_o` is a square wave with an exact 50% duty cycle.

The divide setting and the bypass bit come from a register that sits outside the block. The block keeps its own working copy of both. It updates that copy only at the end of an output period, so a write made in the middle of a period never shortens or stretches that period. Reset puts the working copy at the fastest divided rate, which is divide-by-2, with bypass off.

Top module: `clk_prescaler`

## Requirements
- R1: Reset sets the working divide setting to FFh and clears bypass, whatever the inputs are. In the cycle after reset is released, `ce_o` and `clk_div_o` are both 0. In the following cycle both are 1, which completes the first divide-by-2 period.
- R2: With bypass off and a setting K in effect, `ce_o` is high for exactly one cycle in every 512 − 2·K oscillator cycles.
- R3: Each divided period begins with `clk_div_o` low for 256 − K cycles, followed by `clk_div_o` high for 256 − K cycles. The `ce_o` pulse falls on the last high cycle.
- R4: K = FFh gives a period of 2 cycles, and K = 00h gives a period of 512 cycles.
- R5: The inputs are sampled only in a cycle where `ce_o` is high. A setting sampled there governs the period that starts in the next cycle. A change on `reload_i` in any other cycle leaves the period in progress unchanged.
- R6: While bypass is in effect, `ce_o` is high in every cycle, `clk_div_o` stays 0, and `reload_i` has no effect on either output.
- R7: A bypass request made in the middle of a period takes effect only after that period's `ce_o` pulse. When bypass is released, a full divided period of the newly sampled setting begins in the next cycle.
- R8: K = FEh gives a ratio of 4, so a 12 MHz oscillator yields a 3 MHz rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reload_i | input | 8 | Divide setting K from the control register |
| bypass_i | input | 1 | Double-speed request: 1 passes every oscillator cycle through |
| ce_o | output | 1 | One-cycle enable pulse at the divided rate |
| clk_div_o | output | 1 | 50% duty square wave at the divided rate |

## Verification
A wrong half-period count, or a setting captured at the wrong moment, shows up within a single output period. It appears as a gap between `ce_o` pulses that differs from 512 − 2·K, or as a high time of `clk_div_o` that differs from 256 − K. The bench sweeps every setting from FFh to 00h and measures both quantities for each one, so any such fault is caught within at most 512 cycles. A faulty update rule shows up in the period that straddles a mid-period write: that period has the wrong length, or a bypass pulse appears before the pending `ce_o`. Faults in the reset defaults show up in the first two cycles after reset.

// File: rtl/ckpre_pkg.sv
package ckpre_pkg;

  // Cycles spent in each half of a divided period: 2**w - k.
  function automatic int unsigned half_cycles(input int unsigned k, input int unsigned w);
    return (32'd1 << w) - k;
  endfunction

  // Full output period in oscillator cycles: 2**(w+1) - 2k.
  function automatic int unsigned period_cycles(input int unsigned k, input int unsigned w);
    return 2 * half_cycles(k, w);
  endfunction

endpackage

// File: rtl/ckpre_shadow.sv
module ckpre_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] k_i,
  input  logic         byp_i,
  output logic [W-1:0] k_q_o,
  output logic         byp_q_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      k_q_o   <= '1;
      byp_q_o <= 1'b0;
    end else if (load_i) begin
      k_q_o   <= k_i;
      byp_q_o <= byp_i;
    end
  end

  // R5
  hold_between_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(k_q_o) && $stable(byp_q_o)));

endmodule

// File: rtl/ckpre_halfcnt.sv
module ckpre_halfcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] k_i,
  input  logic         hold_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);

  localparam int unsigned CW = W + 1;

  logic [CW-1:0] half_len;
  logic [CW-1:0] cnt_ext;

  assign half_len = CW'(ckpre_pkg::half_cycles(int'(k_i), W));
  assign cnt_ext  = {1'b0, cnt_o};
  assign tc_o     = !hold_i && (cnt_ext == half_len - CW'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (hold_i || tc_o)   cnt_o <= '0;
    else                       cnt_o <= cnt_o + W'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ext < half_len);

  // R6
  cnt_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_o == '0));

endmodule

// File: rtl/ckpre_phase.sv
module ckpre_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  input  logic hold_i,
  output logic phase_o,
  output logic boundary_o
);

  assign boundary_o = hold_i || (tc_i && phase_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     phase_o <= 1'b0;
    else if (hold_i) phase_o <= 1'b0;
    else if (tc_i)   phase_o <= ~phase_o;
  end

  // R3
  phase_moves_on_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !tc_i) |=> $stable(phase_o));

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] reload_i,
  input  logic         bypass_i,
  output logic         ce_o,
  output logic         clk_div_o
);

  logic [W-1:0] k_q;
  logic         byp_q;
  logic [W-1:0] cnt;
  logic         tc;
  logic         phase;
  logic         boundary;

  ckpre_shadow #(.W(W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (boundary),
    .k_i     (reload_i),
    .byp_i   (bypass_i),
    .k_q_o   (k_q),
    .byp_q_o (byp_q)
  );

  ckpre_halfcnt #(.W(W)) u_halfcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .k_i    (k_q),
    .hold_i (byp_q),
    .cnt_o  (cnt),
    .tc_o   (tc)
  );

  ckpre_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tc_i       (tc),
    .hold_i     (byp_q),
    .phase_o    (phase),
    .boundary_o (boundary)
  );

  assign ce_o      = boundary;
  assign clk_div_o = phase;

  // R6
  bypass_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_q |-> (ce_o && !clk_div_o));

  // R3
  low_half_follows_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o && !byp_q) |=> !clk_div_o);

  // R2
  ce_only_when_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o && !byp_q) |-> clk_div_o);

  // R7
  bypass_enters_at_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byp_q) |-> $past(ce_o));

endmodule

// File: tb/clk_prescaler_tb.sv
module clk_prescaler_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reload = 8'h00;
  logic       bypass = 1'b1;
  logic       ce;
  logic       clk_div;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  clk_prescaler u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .reload_i  (reload),
    .bypass_i  (bypass),
    .ce_o      (ce),
    .clk_div_o (clk_div)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Count negedges up to and including the next ce pulse, with clk_div high cycles.
  task automatic measure(output int len, output int hi);
    len = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      len++;
      if (clk_div) hi++;
    end while (!ce && len < 600);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int len;
    int hi;
    int ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, inputs (K=00, bypass=1) not yet in effect
    check(!ce && !clk_div, "R1 first cycle", {ce, clk_div}, 0);
    @(negedge clk);
    check(ce && clk_div, "R1 divide-by-2 end", {ce, clk_div}, 3);
    // bypass sampled at that ce: R6
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ce && !clk_div) ones++;
      reload = 8'(i * 13);
    end
    check(ones == 20, "R6 bypass ce every cycle, K ignored", ones, 20);
    // R7 exit: new divided period starts next cycle (K=FD -> 6)
    reload = 8'hFD;
    bypass = 1'b0;
    measure(len, hi);
    check(len == 6, "R7 exit period", len, 6);
    check(hi == 3, "R7 exit high time", hi, 3);

    // R2 R3 R4 R8: sweep every setting
    for (int k = 255; k >= 0; k--) begin
      reload = 8'(k);
      measure(len, hi);
      check(len == 512 - 2 * k, (k == 255 || k == 0) ? "R4 period" :
            (k == 254) ? "R8 period" : "R2 period", len, 512 - 2 * k);
      check(hi == 256 - k, "R3 high time", hi, 256 - k);
      check(clk_div == 1'b1, "R3 ce on last high cycle", clk_div, 1);
    end

    // R5: mid-period write leaves current period intact
    reload = 8'hF0;
    measure(len, hi);
    check(len == 32, "R5 setup period", len, 32);
    repeat (5) @(negedge clk);
    reload = 8'hFE;
    measure(len, hi);
    check(len == 27 && hi == 16, "R5 period kept", len, 27);
    measure(len, hi);
    check(len == 4 && hi == 2, "R5 new setting", len, 4);

    // R7 entry: bypass request mid-period waits for ce
    reload = 8'hF0;
    measure(len, hi);
    repeat (3) @(negedge clk);
    bypass = 1'b1;
    measure(len, hi);
    check(len == 29, "R7 bypass waits for ce", len, 29);
    @(negedge clk);
    check(ce && !clk_div, "R7 bypass active after ce", {ce, clk_div}, 2);
    bypass = 1'b0;
    reload = 8'hFF;
    measure(len, hi);
    check(len == 2, "R7 exit to divide-by-2", len, 2);

    finish_run();
  end

endmodule